// File: doc/BRIEF.md
# Flash Program/Erase Controller with Key Unlock

This block drives word programming and page erasure on an on-chip nonvolatile array, modelled here as a small synthesizable memory that starts out fully erased. Software talks to it through four 32-bit registers: control, key, address and data. Every register write carries a mode that selects a plain overwrite, an OR of the written bits into the register, or a clear of the written bits.

An operation runs only after a three-value key sequence has armed the controller, write enable is set, and the start bit is then written. The start bit reads back as a busy flag for a parameterised number of cycles, with one count for word writes and another for page erases. It then drops by itself. Programming can only move bits from 1 to 0. Erasing sets every word of the addressed page to all ones.

Two error flags report problems. One is set when a start is refused. The other is set when a low-voltage input aborts a running operation. Both are cleared by running an armed no-operation.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, the control register reads 0 and every array word reads 0xFFFFFFFF.
- R2: Registers are selected as 0 control, 1 key, 2 address and 3 data. Write mode 0 overwrites, mode 1 clears the written bits, mode 2 ORs them in, and mode 3 acts as an overwrite. Address and data read back accordingly.
- R3: Control holds the operation code in bits 3:0, the start/busy flag in bit 15, write enable in bit 14, the write-error flag in bit 13 and the low-voltage-error flag in bit 12. All other bits read 0. The start succeeds only if the key register has received 0x00000000, 0xAA996655 and 0x556699AA in that order. Bit 15 then reads 1 for exactly WRITE_CYC cycles for codes 0 and 1, or ERASE_CYC cycles for code 4, and then clears by itself.
- R4: Code 1 replaces the word at address bits WORD_AW+1:2 with the old word ANDed with the data register.
- R5: Code 4 sets every word of the page containing the address to all ones and leaves the other pages unchanged.
- R6: Setting bit 15 while write enable would be 0 after the write does nothing: bit 15 stays 0, no error flag is set and the array is unchanged.
- R7: A start with write enable set but without the completed key sequence sets bit 13 and leaves the array unchanged. A key value other than the expected next one returns the sequence to idle. A zero always restarts the sequence.
- R8: If the low-voltage input is high during a busy cycle, the operation aborts at that edge: bit 15 clears, bit 12 sets and the array is unchanged.
- R9: An armed start clears bits 13 and 12. A no-operation therefore serves as error recovery.
- R10: While busy, writes to address, data and the operation code are ignored. Each start attempt, accepted or refused, consumes the unlock, so the next start needs a new key sequence.
- R11: An armed start with a code other than 0, 1 or 4 is refused: bit 13 sets and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register selected for write |
| bus_mode | input | 2 | Write mode: overwrite, clear bits, set bits |
| bus_wdata | input | 32 | Write data |
| bus_rsel | input | 2 | Register selected for read |
| bus_rdata | output | 32 | Read data (key reads 0) |
| lvd_in | input | 1 | Low-voltage condition |
| arr_raddr | input | WORD_AW | Array word read index |
| arr_rdata | output | 32 | Array word read data |

## Verification
A wrong unlock state shows up at the next start: bit 15 stays low, or bit 13 rises when it should not, one cycle after the start write. A wrong busy counter changes the number of cycles bit 15 stays high. That count is measured for both durations. A wrong array update shows up as soon as the busy flag drops, because the bench compares every word with an arithmetic model after each operation. This covers writes that hit the wrong word, erases that spill into another page, and aborted operations that still changed the array.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_KEY  = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_WORD  = 4'd1;
  localparam logic [3:0] OP_ERASE = 4'd4;

  localparam int BIT_BUSY = 15;
  localparam int BIT_WREN = 14;

  localparam logic [31:0] KEY_FIRST  = 32'hAA996655;
  localparam logic [31:0] KEY_SECOND = 32'h556699AA;

  // mode 1 clears written bits, mode 2 ORs them, others overwrite
  function automatic logic [31:0] merge_write(input logic [31:0] old_v,
                                              input logic [31:0] w,
                                              input logic [1:0] mode);
    case (mode)
      2'd1:    return old_v & ~w;
      2'd2:    return old_v | w;
      default: return w;
    endcase
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    return (op == OP_NOP) || (op == OP_WORD) || (op == OP_ERASE);
  endfunction

  function automatic logic [31:0] program_word(input logic [31:0] old_v,
                                               input logic [31:0] d);
    return old_v & d;
  endfunction
endpackage

// File: rtl/flash_keylock.sv
module flash_keylock import flash_ctrl_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        consume,
  output logic        armed
);
  typedef enum logic [1:0] {KS_IDLE, KS_ZERO, KS_ONE, KS_ARMED} key_state_e;
  key_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    if (consume) st_nx = KS_IDLE;
    else if (key_wr) begin
      if (key_val == 32'd0) st_nx = KS_ZERO;
      else if (st == KS_ZERO && key_val == KEY_FIRST) st_nx = KS_ONE;
      else if (st == KS_ONE && key_val == KEY_SECOND) st_nx = KS_ARMED;
      else st_nx = KS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= KS_IDLE;
    else        st <= st_nx;

  assign armed = (st == KS_ARMED);
endmodule

// File: rtl/flash_seq.sv
module flash_seq import flash_ctrl_pkg::*; #(
  parameter int WRITE_CYC = 4,
  parameter int ERASE_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] start_op,
  input  logic       lvd,
  output logic       busy,
  output logic       commit,
  output logic       abort
);
  localparam int MAXD = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= (start_op == OP_ERASE) ? CW'(ERASE_CYC - 1) : CW'(WRITE_CYC - 1);
    end else if (busy) begin
      if (lvd || cnt == '0) busy <= 1'b0;
      else                  cnt  <= cnt - 1'b1;
    end

  assign commit = busy && !lvd && (cnt == '0);
  assign abort  = busy && lvd;
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int WORD_AW = 6,
  parameter int PAGE_AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_word,
  input  logic               we_page,
  input  logic [WORD_AW-1:0] waddr,
  input  logic [31:0]        wdata,
  input  logic [WORD_AW-1:0] raddr,
  output logic [31:0]        rdata
);
  localparam int NWORDS = 1 << WORD_AW;
  logic [31:0] mem [NWORDS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < NWORDS; i++) begin
        if (we_page && (WORD_AW'(i) >> PAGE_AW) == (waddr >> PAGE_AW))
          mem[i] <= '1;
        else if (we_word && WORD_AW'(i) == waddr)
          mem[i] <= wdata;
      end
    end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl import flash_ctrl_pkg::*; #(
  parameter int WORD_AW    = 6,
  parameter int PAGE_WORDS = 8,
  parameter int WRITE_CYC  = 4,
  parameter int ERASE_CYC  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [1:0]         bus_sel,
  input  logic [1:0]         bus_mode,
  input  logic [31:0]        bus_wdata,
  input  logic [1:0]         bus_rsel,
  output logic [31:0]        bus_rdata,
  input  logic               lvd_in,
  input  logic [WORD_AW-1:0] arr_raddr,
  output logic [31:0]        arr_rdata
);
  localparam int PAGE_AW = $clog2(PAGE_WORDS);

  logic [3:0]  op_q;
  logic        wren_q, wrerr_q, lvderr_q;
  logic [31:0] addr_q, data_q;
  logic        busy, armed, op_commit, op_abort;

  // named internal events
  logic        wr_ctrl, wr_key, wr_addr, wr_data;
  logic        start_req, start_ok, start_refused;
  logic        arr_we_word, arr_we_page, arr_we;
  logic [31:0] ctrl_view, ctrl_next;
  logic [WORD_AW-1:0] word_idx;
  logic [31:0] old_word;

  assign wr_ctrl = bus_wr && bus_sel == SEL_CTRL;
  assign wr_key  = bus_wr && bus_sel == SEL_KEY;
  assign wr_addr = bus_wr && bus_sel == SEL_ADDR;
  assign wr_data = bus_wr && bus_sel == SEL_DATA;

  assign ctrl_view = {16'd0, busy, wren_q, wrerr_q, lvderr_q, 8'd0, op_q};
  assign ctrl_next = merge_write(ctrl_view, bus_wdata, bus_mode);

  assign start_req     = wr_ctrl && !busy && ctrl_next[BIT_BUSY] && ctrl_next[BIT_WREN];
  assign start_ok      = start_req && armed && op_known(ctrl_next[3:0]);
  assign start_refused = start_req && !(armed && op_known(ctrl_next[3:0]));

  flash_keylock u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(wr_key),
    .key_val(merge_write(32'd0, bus_wdata, bus_mode)),
    .consume(start_req), .armed(armed)
  );

  flash_seq #(.WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .start_op(ctrl_next[3:0]),
    .lvd(lvd_in), .busy(busy), .commit(op_commit), .abort(op_abort)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_q     <= OP_NOP;
      wren_q   <= 1'b0;
      wrerr_q  <= 1'b0;
      lvderr_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      if (wr_ctrl) wren_q <= ctrl_next[BIT_WREN];
      if (wr_ctrl && !busy) op_q <= ctrl_next[3:0];
      if (wr_addr && !busy) addr_q <= merge_write(addr_q, bus_wdata, bus_mode);
      if (wr_data && !busy) data_q <= merge_write(data_q, bus_wdata, bus_mode);
      if (start_ok) begin
        wrerr_q  <= 1'b0;
        lvderr_q <= 1'b0;
      end else if (start_refused) wrerr_q <= 1'b1;
      if (op_abort) lvderr_q <= 1'b1;
    end

  assign word_idx    = addr_q[WORD_AW+1:2];
  assign arr_we_word = op_commit && op_q == OP_WORD;
  assign arr_we_page = op_commit && op_q == OP_ERASE;
  assign arr_we      = arr_we_word || arr_we_page;

  flash_array #(.WORD_AW(WORD_AW), .PAGE_AW(PAGE_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .we_word(arr_we_word), .we_page(arr_we_page),
    .waddr(word_idx), .wdata(program_word(old_word, data_q)),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );
  assign old_word = u_arr.mem[word_idx];

  always_comb
    case (bus_rsel)
      SEL_CTRL: bus_rdata = ctrl_view;
      SEL_ADDR: bus_rdata = addr_q;
      SEL_DATA: bus_rdata = data_q;
      default:  bus_rdata = 32'd0;
    endcase

  logic unused_bits;
  assign unused_bits = ^{addr_q[31:WORD_AW+2], addr_q[1:0], ctrl_next[31:16], ctrl_next[13:4]};
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int ERASE_CYC = 10,
  parameter int WRITE_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic armed,
  input logic start_ok,
  input logic start_refused,
  input logic op_commit,
  input logic op_abort,
  input logic arr_we,
  input logic lvd_in,
  input logic wrerr_q,
  input logic lvderr_q
);
  localparam int MAXD = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_run <= 0;
    else        busy_run <= busy ? busy_run + 1 : 0;

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= MAXD);
  p_start_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  p_array_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  p_refused_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_refused |=> (wrerr_q && !busy));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lvd_in) |=> (!busy && lvderr_q));
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (!wrerr_q && !lvderr_q && busy));
  p_unlock_used_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok || start_refused) |=> !armed);
  p_busy_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_commit && !op_abort) |=> busy);
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .armed(armed), .start_ok(start_ok),
  .start_refused(start_refused), .op_commit(op_commit), .op_abort(op_abort),
  .arr_we(arr_we), .lvd_in(lvd_in), .wrerr_q(wrerr_q), .lvderr_q(lvderr_q)
);

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
  localparam int AW = 6;
  localparam int PW = 8;
  localparam int WC = 4;
  localparam int EC = 10;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, lvd_in = 1'b0;
  logic [1:0] bus_sel = 2'd0, bus_mode = 2'd0, bus_rsel = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata, arr_rdata;
  logic [AW-1:0] arr_raddr = '0;

  int errors = 0, checks = 0;
  logic [31:0] expm [NW];

  always #10 clk = ~clk;

  flash_prog_ctrl #(.WORD_AW(AW), .PAGE_WORDS(PW), .WRITE_CYC(WC), .ERASE_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_mode(bus_mode),
    .bus_wdata(bus_wdata), .bus_rsel(bus_rsel), .bus_rdata(bus_rdata),
    .lvd_in(lvd_in), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata));

  function automatic logic [31:0] mkctrl(input bit b, input bit we, input bit e1,
                                         input bit e2, input logic [3:0] op);
    return (32'(b) << 15) | (32'(we) << 14) | (32'(e1) << 13) | (32'(e2) << 12) | 32'(op);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] mode, input logic [31:0] d);
    bus_wr = 1'b1; bus_sel = sel; bus_mode = mode; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    bus_rsel = sel; #1; v = bus_rdata;
  endtask

  task automatic unlock();
    wr(2'd1, 2'd0, 32'h0);
    wr(2'd1, 2'd0, 32'hAA996655);
    wr(2'd1, 2'd0, 32'h556699AA);
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] c;
    n = 0;
    rd(2'd0, c);
    while (c[15] && n < 100) begin
      @(negedge clk); n++; rd(2'd0, c);
    end
  endtask

  // full armed sequence; returns busy cycles
  task automatic run_op(input logic [3:0] op, output int n);
    wr(2'd0, 2'd0, 32'(op));
    wr(2'd0, 2'd2, 32'h4000);
    unlock();
    wr(2'd0, 2'd2, 32'h8000);
    wait_idle(n);
    wr(2'd0, 2'd1, 32'h4000);
  endtask

  task automatic check_array(input string req);
    for (int i = 0; i < NW; i++) begin
      arr_raddr = AW'(i); #1;
      check(req, arr_rdata, expm[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    for (int i = 0; i < NW; i++) expm[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'h0);
    check_array("R1 array");

    // R2 write modes
    wr(2'd2, 2'd0, 32'h0000_00F0); rd(2'd2, v); check("R2 raw", v, 32'hF0);
    wr(2'd2, 2'd2, 32'h3);         rd(2'd2, v); check("R2 set", v, 32'hF3);
    wr(2'd2, 2'd1, 32'h30);        rd(2'd2, v); check("R2 clr", v, 32'hC3);
    wr(2'd3, 2'd3, 32'h1234_5678); rd(2'd3, v); check("R2 mode3", v, 32'h12345678);
    wr(2'd3, 2'd1, 32'h0000_0078); rd(2'd3, v); check("R2 data clr", v, 32'h12345600);

    // R3 R4 word write sweep, two passes on the same words
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < NW / PW; p++) begin
        int w;
        logic [31:0] d;
        w = p * PW + p;
        d = pass == 0 ? ~(32'h11 << (p * 3)) : ~(32'h100 << p) & 32'hF0FF_FFFF;
        wr(2'd2, 2'd0, 32'(w * 4));
        wr(2'd3, 2'd0, d);
        run_op(4'd1, n);
        check("R3 write busy cycles", 32'(n), 32'(WC));
        expm[w] = expm[w] & d;
      end
      check_array("R4 word write");
    end

    // R5 erase even pages via an address inside the page
    for (int p = 0; p < NW / PW; p += 2) begin
      wr(2'd2, 2'd0, 32'(p * PW * 4 + 12));
      run_op(4'd4, n);
      check("R3 erase busy cycles", 32'(n), 32'(EC));
      for (int i = 0; i < PW; i++) expm[p * PW + i] = '1;
    end
    check_array("R5 page erase");

    // R6 start with write enable clear
    wr(2'd2, 2'd0, 32'(9 * 4));
    wr(2'd3, 2'd0, 32'h0);
    wr(2'd0, 2'd0, 32'h1);
    unlock();
    wr(2'd0, 2'd2, 32'h8000);
    rd(2'd0, v); check("R6 no start", v, mkctrl(0, 0, 0, 0, 4'd1));
    arr_raddr = AW'(9); #1; check("R6 array", arr_rdata, expm[9]);
    wr(2'd1, 2'd0, 32'h1234);

    // R7 no unlock
    wr(2'd0, 2'd0, 32'hC001);
    rd(2'd0, v); check("R7 refused", v, mkctrl(0, 1, 1, 0, 4'd1));
    arr_raddr = AW'(9); #1; check("R7 array", arr_rdata, expm[9]);

    // R9 recovery by no-operation
    run_op(4'd0, n);
    check("R9 nop busy", 32'(n), 32'(WC));
    rd(2'd0, v); check("R9 cleared", v, mkctrl(0, 0, 0, 0, 4'd0));

    // R7 broken key sequence
    wr(2'd0, 2'd0, 32'h4001);
    wr(2'd1, 2'd0, 32'h0);
    wr(2'd1, 2'd0, 32'hAA996655);
    wr(2'd1, 2'd0, 32'hDEAD0000);
    wr(2'd1, 2'd0, 32'h556699AA);
    wr(2'd0, 2'd2, 32'h8000);
    rd(2'd0, v); check("R7 broken key", v, mkctrl(0, 1, 1, 0, 4'd1));
    arr_raddr = AW'(9); #1; check("R7 broken key array", arr_rdata, expm[9]);
    run_op(4'd0, n);

    // R8 low-voltage abort
    wr(2'd0, 2'd0, 32'h4001);
    unlock();
    wr(2'd0, 2'd2, 32'h8000);
    lvd_in = 1'b1;
    @(negedge clk);
    lvd_in = 1'b0;
    rd(2'd0, v); check("R8 abort", v, mkctrl(0, 1, 0, 1, 4'd1));
    arr_raddr = AW'(9); #1; check("R8 array", arr_rdata, expm[9]);
    run_op(4'd0, n);
    rd(2'd0, v); check("R9 after abort", v, mkctrl(0, 0, 0, 0, 4'd0));

    // R10 writes ignored while busy, unlock consumed
    wr(2'd2, 2'd0, 32'(17 * 4));
    wr(2'd3, 2'd0, 32'hFFFF_0F0F);
    wr(2'd0, 2'd0, 32'h4001);
    unlock();
    wr(2'd0, 2'd2, 32'h8000);
    wr(2'd2, 2'd0, 32'(3 * 4));
    wr(2'd3, 2'd0, 32'h0);
    wr(2'd0, 2'd0, 32'h4004);
    rd(2'd2, v); check("R10 addr held", v, 32'(17 * 4));
    rd(2'd3, v); check("R10 data held", v, 32'hFFFF0F0F);
    rd(2'd0, v); check("R10 op held", v, mkctrl(1, 1, 0, 0, 4'd1));
    wait_idle(n);
    expm[17] = expm[17] & 32'hFFFF0F0F;
    check_array("R10 array after busy writes");
    wr(2'd0, 2'd2, 32'h8000);
    rd(2'd0, v); check("R10 unlock consumed", v, mkctrl(0, 1, 1, 0, 4'd1));
    run_op(4'd0, n);

    // R11 unsupported code
    wr(2'd0, 2'd0, 32'h4002);
    unlock();
    wr(2'd0, 2'd2, 32'h8000);
    rd(2'd0, v); check("R11 bad op", v, mkctrl(0, 1, 1, 0, 4'd2));
    check_array("R11 array");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule